// File: doc/BRIEF.md
# Quad-SPI Command Frame Sequencer

This block produces the framing of one flash command on a quad-SPI bus: the chip select, the serial clock and a phase code that tells a neighbouring data path which part of the command is on the wires. A command runs through a lead-in, an instruction phase, an address phase, a data phase and a lead-out. Any of the three transfer phases can be left out by giving it a length of zero. The serial clock is made by dividing the system clock with a programmable prescaler. Each serial half period lasts `presc+1` system clocks, and every phase moves forward only on that divided tick.

A small configuration register holds three settings: the instruction mode, a send-once flag and the clock polarity mode. All three are captured on a configuration write strobe. When send-once is set, only the first command after a configuration write carries the instruction. Commands that follow skip it until the register is written again. An abort input drops the command at once and returns the block to idle.

The states are IDLE (0), LEAD (1), INSTR (2), ADDR (3), DATA (4), TRAIL (5) and DONE (6). The `phase` port presents the state code. The transitions are:
- IDLE goes to LEAD on start.
- LEAD goes on a tick to the first included phase, or to TRAIL if there is none.
- Each transfer phase goes to the next included phase, or to TRAIL, after its last serial cycle.
- TRAIL goes to DONE on a tick.
- DONE goes to IDLE unconditionally.
- Abort sends any state to IDLE.

Top module: `qfs_frame_seq`

## Requirements
- R1: After reset the outputs are `cs_n`=1, `sclk`=0, `phase`=0 (IDLE) and `done`=0. The send-once memory starts as "instruction pending".
- R2: `cfg_wr` captures `cfg_imode`, `cfg_once` and `cfg_cpol`. While `cs_n` is high, `sclk` equals `cfg_cpol`. With `cfg_cpol`=0 the active edge is rising; with `cfg_cpol`=1 it is falling. The frame has exactly one active edge per serial cycle.
- R3: One serial half period lasts `presc+1` system clocks. `cs_n` stays low for (presc+1)*(2*N+2) system clocks, where N is the number of serial cycles in the frame.
- R4: The phases run in the order INSTR (2), ADDR (3), DATA (4). Each phase lasts its length in serial cycles, i.e. 2*(presc+1)*len system clocks. A phase of length zero does not appear.
- R5: `cs_n` falls exactly one serial period (2*(presc+1) system clocks) before the first active edge, and `phase` is LEAD (1) at that moment.
- R6: `cs_n` rises exactly one serial period after the last active edge. `done` is high for exactly one system clock, in the cycle in which `cs_n` returns high and after TRAIL (5).
- R7: With `cfg_imode`=0 no frame has an instruction phase, whatever the send-once flag is.
- R8: With `cfg_once`=1 and `cfg_imode`≠0, only the first frame whose instruction phase completes after a configuration write (or after reset) carries the instruction. Later frames skip it until the next `cfg_wr`.
- R9: With `cfg_once`=0 and `cfg_imode`≠0, every frame with a nonzero `instr_len` carries the instruction.
- R10: When `abort` is high while a frame is active, the next cycle shows `cs_n`=1, `phase`=IDLE and `sclk` at its idle level, and no `done` follows.
- R11: A `start` that arrives while a frame is active is ignored. It neither changes the frame nor starts a second one.
- R12: A frame in which no phase has cycles still pulls `cs_n` low for one serial period, 2*(presc+1) system clocks, and gives no clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_imode | input | 2 | Instruction mode; 0 means no instruction |
| cfg_once | input | 1 | Send the instruction only once per configuration write |
| cfg_cpol | input | 1 | Clock mode: idle level of the serial clock |
| presc | input | PRESC_W | Half-period divider minus one |
| start | input | 1 | Start a frame (taken in IDLE only) |
| abort | input | 1 | Abandon the current frame |
| instr_len | input | LEN_W | Instruction phase length in serial cycles |
| addr_len | input | LEN_W | Address phase length in serial cycles |
| data_len | input | LEN_W | Data phase length in serial cycles |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| phase | output | 3 | Current state code |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The hardest situation to reach is the send-once memory over a run of frames. Whether an instruction appears depends on every configuration write and every completed instruction phase since reset, not on the current inputs. The stimulus mixes directed sequences (a write followed by several frames, a mode change, an instruction length of zero) with seeded random frames that interleave random configuration writes. A bench model of the pending flag predicts every frame's instruction length. Abort is injected at random points inside long frames, so that it lands in every phase and at both half periods of the serial clock.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_INSTR = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DATA  = 3'd4,
        ST_TRAIL = 3'd5,
        ST_DONE  = 3'd6
    } qfs_state_e;
endpackage

// File: rtl/qfs_tick.sv
// Half-period tick generator: one pulse every presc+1 clocks while run is high.
module qfs_tick #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == presc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

    assign tick = run && (cnt_q == presc);
endmodule

// File: rtl/qfs_once.sv
// Remembers whether the instruction still has to be sent since the last configuration write.
module qfs_once (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic clear,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b1;
        end else if (cfg_wr) begin
            pending <= 1'b1;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/qfs_frame_seq.sv
module qfs_frame_seq
    import qfs_pkg::*;
#(
    parameter int PRESC_W = 8,
    parameter int LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_imode,
    input  logic               cfg_once,
    input  logic               cfg_cpol,
    input  logic [PRESC_W-1:0] presc,
    input  logic               start,
    input  logic               abort,
    input  logic [LEN_W-1:0]   instr_len,
    input  logic [LEN_W-1:0]   addr_len,
    input  logic [LEN_W-1:0]   data_len,
    output logic               cs_n,
    output logic               sclk,
    output logic [2:0]         phase,
    output logic               done
);
    qfs_state_e state_q, state_d;
    logic             hb_q, hb_d;
    logic [LEN_W-1:0] bcnt_q, bcnt_d;
    logic [LEN_W-1:0] ilen_q, alen_q, dlen_q;
    logic [1:0]       imode_q;
    logic             once_q, cpol_q, incl_q;
    logic             tick, run, pending, instr_end, shifting;
    qfs_state_e after_lead, after_instr, after_addr;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imode_q <= 2'd1;
            once_q  <= 1'b0;
            cpol_q  <= 1'b0;
        end else if (cfg_wr) begin
            imode_q <= cfg_imode;
            once_q  <= cfg_once;
            cpol_q  <= cfg_cpol;
        end
    end

    // per-frame lengths and instruction decision, taken at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilen_q <= '0;
            alen_q <= '0;
            dlen_q <= '0;
            incl_q <= 1'b0;
        end else if (state_q == ST_IDLE && start && !abort) begin
            ilen_q <= instr_len;
            alen_q <= addr_len;
            dlen_q <= data_len;
            incl_q <= (imode_q != 2'd0) && (!once_q || pending);
        end
    end

    assign run = (state_q != ST_IDLE) && (state_q != ST_DONE);

    qfs_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .presc (presc),
        .tick  (tick)
    );

    assign instr_end = (state_q == ST_INSTR) && tick && hb_q && (bcnt_q == '0);

    qfs_once u_once (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .clear   (instr_end && once_q),
        .pending (pending)
    );

    assign after_addr  = (dlen_q != '0) ? ST_DATA : ST_TRAIL;
    assign after_instr = (alen_q != '0) ? ST_ADDR : after_addr;
    assign after_lead  = (incl_q && ilen_q != '0) ? ST_INSTR : after_instr;

    function automatic logic [LEN_W-1:0] first_count(input qfs_state_e st,
                                                     input logic [LEN_W-1:0] il,
                                                     input logic [LEN_W-1:0] al,
                                                     input logic [LEN_W-1:0] dl);
        unique case (st)
            ST_INSTR: first_count = il - LEN_W'(1);
            ST_ADDR:  first_count = al - LEN_W'(1);
            ST_DATA:  first_count = dl - LEN_W'(1);
            default:  first_count = '0;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        qfs_state_e nxt;
        state_d = state_q;
        hb_d    = hb_q;
        bcnt_d  = bcnt_q;
        nxt     = ST_TRAIL;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d = after_lead;
                    hb_d    = 1'b0;
                    bcnt_d  = first_count(after_lead, ilen_q, alen_q, dlen_q);
                end
            end
            ST_INSTR, ST_ADDR, ST_DATA: begin
                if (state_q == ST_INSTR)     nxt = after_instr;
                else if (state_q == ST_ADDR) nxt = after_addr;
                else                         nxt = ST_TRAIL;
                if (tick) begin
                    if (!hb_q) begin
                        hb_d = 1'b1;
                    end else begin
                        hb_d = 1'b0;
                        if (bcnt_q == '0) begin
                            state_d = nxt;
                            bcnt_d  = first_count(nxt, ilen_q, alen_q, dlen_q);
                        end else begin
                            bcnt_d = bcnt_q - LEN_W'(1);
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
            hb_d    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hb_q    <= 1'b0;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hb_q    <= hb_d;
            bcnt_q  <= bcnt_d;
        end
    end

    // outputs
    always_comb begin
        shifting = (state_q == ST_INSTR) || (state_q == ST_ADDR) || (state_q == ST_DATA);
        cs_n     = (state_q == ST_IDLE) || (state_q == ST_DONE);
        sclk     = cpol_q ^ (shifting && hb_q);
        phase    = state_q;
        done     = (state_q == ST_DONE);
    end
endmodule

// File: rtl/qfs_frame_sva.sv
module qfs_frame_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       abort,
    input logic       cs_n,
    input logic       sclk,
    input logic       done,
    input logic [2:0] phase,
    input logic       cpol_q
);
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol_q));

    assert_cs_fall_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (phase == 3'd1));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == 3'd5));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && phase != 3'd0) |=> (cs_n && phase == 3'd0 && !done));
endmodule

bind qfs_frame_seq qfs_frame_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (abort),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .done   (done),
    .phase  (phase),
    .cpol_q (cpol_q)
);

// File: tb/qfs_frame_seq_tb.sv
`timescale 1ns/1ps
module qfs_frame_seq_tb;
    localparam int PRESC_W = 8;
    localparam int LEN_W   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_once = 1'b0, cfg_cpol = 1'b0;
    logic [1:0] cfg_imode = 2'd1;
    logic [PRESC_W-1:0] presc = '0;
    logic start = 1'b0, abort = 1'b0;
    logic [LEN_W-1:0] instr_len = '0, addr_len = '0, data_len = '0;
    logic cs_n, sclk, done;
    logic [2:0] phase;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // bench model of the configuration and the pending flag
    int  m_imode = 1;
    bit  m_once = 0, m_cpol = 0, m_pend = 1;

    always #5 clk = ~clk;

    qfs_frame_seq #(.PRESC_W(PRESC_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_imode(cfg_imode),
        .cfg_once(cfg_once), .cfg_cpol(cfg_cpol), .presc(presc), .start(start),
        .abort(abort), .instr_len(instr_len), .addr_len(addr_len), .data_len(data_len),
        .cs_n(cs_n), .sclk(sclk), .phase(phase), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int im, input bit so, input bit cp);
        @(negedge clk);
        cfg_imode = 2'(im); cfg_once = so; cfg_cpol = cp; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_imode = im; m_once = so; m_cpol = cp; m_pend = 1;
        chk("R2 idle level after cfg write", int'(sclk), int'(cp));
    endtask

    function automatic bit exp_incl(input int il);
        return (m_imode != 0) && (!m_once || m_pend) && (il != 0);
    endfunction

    task automatic run_frame(input int p, input int il, input int al, input int dl,
                             input bit mid_start);
        int h, ni, n, low, ins, adr, dat, edges, first, last, fall, rise;
        bit seen, done_rise, prev;
        h = p + 1;
        ni = exp_incl(il) ? il : 0;
        if (ni != 0 && m_once) m_pend = 0;
        n = ni + al + dl;
        low = 0; ins = 0; adr = 0; dat = 0; edges = 0;
        first = -1; last = -1; fall = -1; rise = -1; seen = 0; done_rise = 0;
        @(negedge clk);
        presc = PRESC_W'(p); instr_len = LEN_W'(il); addr_len = LEN_W'(al);
        data_len = LEN_W'(dl); start = 1'b1;
        prev = sclk;
        for (int t = 1; t < 4000; t++) begin
            @(negedge clk);
            if (!cs_n) begin
                low++;
                if (!seen) begin
                    fall = t;
                    chk("R5 phase at cs fall is LEAD", int'(phase), 1);
                end
                seen = 1;
                if (phase == 3'd2) ins++;
                if (phase == 3'd3) adr++;
                if (phase == 3'd4) dat++;
                if (prev == m_cpol && sclk != m_cpol) begin
                    edges++;
                    if (first < 0) first = t;
                    last = t;
                end
            end else if (seen) begin
                rise = t;
                done_rise = done;
                break;
            end
            prev = sclk;
            start = (mid_start && t == 2);
        end
        start = 1'b0;
        chk("R3 cs low length", low, h * (2 * n + 2));
        chk("R4 instr phase length", ins, 2 * h * ni);
        chk("R4 addr phase length", adr, 2 * h * al);
        chk("R4 data phase length", dat, 2 * h * dl);
        chk("R2 active edge count", edges, n);
        if (n > 0) begin
            chk("R5 cs lead gap", first - fall, 2 * h);
            chk("R6 cs trail gap", rise - last, 2 * h);
        end else begin
            chk("R12 empty frame cs low", low, 2 * h);
        end
        chk("R6 done at cs rise", int'(done_rise), 1);
        @(negedge clk);
        chk("R6 done single cycle", int'(done), 0);
        chk("R6 idle after done", int'(phase), 0);
        if (mid_start) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk("R11 no second frame", int'(cs_n), 1);
            end
        end
    endtask

    task automatic abort_frame(input int p, input int wait_n);
        @(negedge clk);
        presc = PRESC_W'(p); instr_len = 6'd4; addr_len = 6'd5; data_len = 6'd6;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < wait_n; k++) @(negedge clk);
        chk("R10 frame active before abort", int'(cs_n), 0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R10 cs high after abort", int'(cs_n), 1);
        chk("R10 phase idle after abort", int'(phase), 0);
        chk("R10 sclk idle after abort", int'(sclk), int'(m_cpol));
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R10 no done after abort", int'(done), 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cs_n", int'(cs_n), 1);
        chk("R1 reset sclk", int'(sclk), 0);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset done", int'(done), 0);

        // R9: instruction every frame when send-once is off
        cfg_write(1, 0, 0);
        run_frame(0, 2, 3, 1, 0);
        run_frame(1, 2, 0, 2, 0);
        // R8: send once, then skip until rewritten
        cfg_write(2, 1, 0);
        run_frame(0, 3, 1, 1, 0);
        run_frame(0, 3, 1, 1, 0);
        run_frame(2, 3, 2, 0, 0);
        cfg_write(2, 1, 0);
        run_frame(1, 1, 1, 1, 0);
        // R7: no instruction mode ignores send-once
        cfg_write(0, 1, 0);
        run_frame(0, 4, 2, 2, 0);
        cfg_write(0, 0, 1);
        run_frame(1, 4, 1, 3, 0);
        // R2: clock mode 1
        cfg_write(3, 0, 1);
        run_frame(3, 2, 2, 2, 0);
        // R12: empty frames
        run_frame(0, 0, 0, 0, 0);
        run_frame(2, 0, 0, 0, 0);
        // R11: start while busy
        run_frame(1, 1, 2, 1, 1);
        run_frame(0, 0, 0, 0, 1);
        // R10: abort at several points
        abort_frame(0, 1);
        abort_frame(1, 7);
        abort_frame(2, 30);
        cfg_write(1, 1, 0);

        // seeded random frames with random configuration writes
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 4) == 0)
                cfg_write(int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
            run_frame(int'($urandom % 4), int'($urandom % 5), int'($urandom % 5),
                      int'($urandom % 5), 1'(($urandom % 5) == 0));
        end
        for (int i = 0; i < 6; i++) begin
            abort_frame(int'($urandom % 3), 1 + int'($urandom % 40));
            cfg_write(int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
            run_frame(int'($urandom % 3), int'($urandom % 4), 1, 1, 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule